// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block sits on the outbound path of a host-to-link bridge. A fixed local memory region, bounded by two parameters, is cut into equal windows whose size software selects as a power of two in mebibytes. Each window owns a programmable 64-bit translated base and a valid flag. A local address presented on the lookup port comes back one cycle later as a 64-bit bus address, together with a hit flag that says whether a window translated it.

Software reaches the control word, the size selector and the per-window base words through a simple word-addressed register port with a write strobe and a combinational read. Translation as a whole is gated by one bit of the control word. Any address the windows do not claim leaves the block zero-extended and unchanged, with the hit flag low.

Top module: `ob_xlat_windows`

## Requirements
- R1: After reset every register reads 0, the output port is empty (out_valid_o = 0) and in_ready_o = 1.
- R2: Window w has a low word at byte offset 0x200 + 8*w and a high word at 0x204 + 8*w; both hold and read back all 32 written bits.
- R3: The size selector at offset 0x030 keeps only written bits 2:0 and reads back zero-extended; its value s sets every window to 2^s MiB.
- R4: The control word at offset 0x004 keeps all 32 written bits; only bit 1 enables translation, the other bits have no effect on it.
- R5: For an address a inside the region, the window index is (a - region base) >> (20 + s).
- R6: On a hit, out_addr_o = {high word, low word with bit 0 cleared} + (a mod 2^(20+s)) and out_hit_o = 1.
- R7: out_hit_o = 0 and out_addr_o = {32'b0, a} when a is outside [base, limit], the index is 32 or more, bit 0 of the window's low word is 0, or control bit 1 is 0.
- R8: An address accepted on a clock edge (in_valid_i and in_ready_o high) is presented on the output with out_valid_o high right after that edge, one result per cycle when out_ready_i stays high.
- R9: While out_valid_o = 1 and out_ready_i = 0, the output holds its address and hit flag and in_ready_o = 0.
- R10: Reads of byte offsets that are no register, including offset 0x300 and up, return 0, and writes there change no register.
- R11: A lookup uses the register values held before the edge on which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| in_valid_i | input | 1 | Lookup request valid |
| in_ready_o | output | 1 | Lookup request accepted when high |
| in_addr_i | input | 32 | Local address to translate |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result consumer ready |
| out_addr_o | output | 64 | Translated or passed-through bus address |
| out_hit_o | output | 1 | A window translated the address |

## Verification
Register reads are combinational, so the read data is due in the same cycle as the offset, while a write takes effect at the next edge and shows up on the read port from then on. A lookup result is due on the output right after the edge that accepts it and stays there until the edge on which out_ready_i is high. The bench drives inputs just after the falling edge, updates a queue-based reference at the rising edge with the inputs then stable, and compares the read data, the ready and valid flags and the head of the expected-result queue at every falling edge, so each result is checked in exactly the cycle it is due and again in every stalled cycle.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;
  localparam int unsigned LOC_W  = 32;
  localparam int unsigned BUS_W  = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned MB_SHIFT = 20;
  localparam int unsigned EN_BIT   = 1;

  localparam int unsigned CTRL_OFS = 'h004;
  localparam int unsigned SIZE_OFS = 'h030;
  localparam int unsigned WIN_OFS  = 'h200;
  localparam int unsigned WIN_STRIDE = 8;

  typedef struct packed {
    logic             hit;
    logic [BUS_W-1:0] addr;
  } xlat_res_t;
endpackage

// File: rtl/ob_xlat_regs.sv
module ob_xlat_regs
  import ob_xlat_pkg::*;
#(
  parameter int unsigned NUM_WIN = 32,
  parameter int unsigned REG_AW  = 12,
  parameter int unsigned SIZE_W  = 3,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            reg_we_i,
  input  logic [REG_AW-1:0]               reg_addr_i,
  input  logic [WORD_W-1:0]               reg_wdata_i,
  output logic [WORD_W-1:0]               reg_rdata_o,
  output logic [WORD_W-1:0]               ctrl_o,
  output logic [SIZE_W-1:0]               size_o,
  output logic [NUM_WIN-1:0][WORD_W-1:0]  win_lo_o,
  output logic [NUM_WIN-1:0][WORD_W-1:0]  win_hi_o
);
  localparam int unsigned WIN_END = WIN_OFS + WIN_STRIDE * NUM_WIN;

  logic              aligned, ctrl_sel, size_sel, win_sel, hi_sel;
  logic [REG_AW-1:0] win_rel;
  logic [IDX_W-1:0]  win_idx;
  logic [WORD_W-1:0] ctrl_q;
  logic [SIZE_W-1:0] size_q;

  assign aligned  = (reg_addr_i[1:0] == 2'b00);
  assign ctrl_sel = (reg_addr_i == REG_AW'(CTRL_OFS));
  assign size_sel = (reg_addr_i == REG_AW'(SIZE_OFS));
  assign win_sel  = aligned && ({1'b0, reg_addr_i} >= (REG_AW+1)'(WIN_OFS))
                            && ({1'b0, reg_addr_i} <  (REG_AW+1)'(WIN_END));
  assign win_rel  = reg_addr_i - REG_AW'(WIN_OFS);
  assign win_idx  = win_rel[IDX_W+2:3];
  assign hi_sel   = win_rel[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      size_q <= '0;
    end else if (reg_we_i) begin
      if (ctrl_sel) ctrl_q <= reg_wdata_i;
      if (size_sel) size_q <= reg_wdata_i[SIZE_W-1:0];
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [WORD_W-1:0] lo_q, hi_q;
    logic              wr_w;
    assign wr_w = reg_we_i && win_sel && (win_idx == IDX_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_w) begin
        if (hi_sel) hi_q <= reg_wdata_i;
        else        lo_q <= reg_wdata_i;
      end
    end
    assign win_lo_o[w] = lo_q;
    assign win_hi_o[w] = hi_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (ctrl_sel)      reg_rdata_o = ctrl_q;
    else if (size_sel) reg_rdata_o = WORD_W'(size_q);
    else if (win_sel)  reg_rdata_o = hi_sel ? win_hi_o[win_idx] : win_lo_o[win_idx];
  end

  assign ctrl_o = ctrl_q;
  assign size_o = size_q;
endmodule

// File: rtl/ob_xlat_lookup.sv
module ob_xlat_lookup
  import ob_xlat_pkg::*;
#(
  parameter int unsigned   NUM_WIN      = 32,
  parameter int unsigned   SIZE_W       = 3,
  parameter logic [31:0]   REGION_BASE  = 32'h4000_0000,
  parameter logic [31:0]   REGION_LIMIT = 32'h4FFF_FFFF,
  localparam int unsigned  IDX_W        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [LOC_W-1:0]                addr_i,
  input  logic                            en_i,
  input  logic [SIZE_W-1:0]               size_i,
  input  logic [NUM_WIN-1:0][WORD_W-1:0]  win_lo_i,
  input  logic [NUM_WIN-1:0][WORD_W-1:0]  win_hi_i,
  output xlat_res_t                       res_o
);
  logic [6:0]        shamt;
  logic [LOC_W-1:0]  rel, idx_full;
  logic [IDX_W-1:0]  idx;
  logic              in_rgn, idx_ok, win_ok, hit;
  logic [BUS_W-1:0]  mask, base, xlat;
  logic [WORD_W-1:0] sel_lo;

  assign shamt    = 7'(MB_SHIFT) + 7'(size_i);
  assign in_rgn   = (addr_i >= REGION_BASE) && (addr_i <= REGION_LIMIT);
  assign rel      = addr_i - REGION_BASE;
  assign idx_full = rel >> shamt;
  assign idx_ok   = idx_full < LOC_W'(NUM_WIN);
  assign idx      = idx_full[IDX_W-1:0];
  assign sel_lo   = win_lo_i[idx];
  assign win_ok   = sel_lo[0];
  assign mask     = (BUS_W'(1) << shamt) - BUS_W'(1);
  // bit 0 carries the valid flag, never address
  assign base     = {win_hi_i[idx], sel_lo[WORD_W-1:1], 1'b0};
  assign xlat     = base + ({{(BUS_W-LOC_W){1'b0}}, addr_i} & mask);
  assign hit      = en_i && in_rgn && idx_ok && win_ok;

  assign res_o.hit  = hit;
  assign res_o.addr = hit ? xlat : {{(BUS_W-LOC_W){1'b0}}, addr_i};
endmodule

// File: rtl/ob_xlat_stage.sv
module ob_xlat_stage
  import ob_xlat_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_valid_i,
  output logic      in_ready_o,
  input  xlat_res_t in_res_i,
  output logic      out_valid_o,
  input  logic      out_ready_i,
  output xlat_res_t out_res_o
);
  logic      valid_q;
  xlat_res_t res_q;

  assign in_ready_o = !valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) res_q <= in_res_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_res_o   = res_q;
endmodule

// File: rtl/ob_xlat_windows.sv
module ob_xlat_windows
  import ob_xlat_pkg::*;
#(
  parameter int unsigned NUM_WIN      = 32,
  parameter int unsigned REG_AW       = 12,
  parameter int unsigned SIZE_W       = 3,
  parameter logic [31:0] REGION_BASE  = 32'h4000_0000,
  parameter logic [31:0] REGION_LIMIT = 32'h4FFF_FFFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [LOC_W-1:0]    in_addr_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [BUS_W-1:0]    out_addr_o,
  output logic                out_hit_o
);
  logic [WORD_W-1:0]              ctrl_q;
  logic [SIZE_W-1:0]              size_q;
  logic [NUM_WIN-1:0][WORD_W-1:0] win_lo, win_hi;
  xlat_res_t                      look_res, out_res;

  ob_xlat_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .SIZE_W(SIZE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .ctrl_o      (ctrl_q),
    .size_o      (size_q),
    .win_lo_o    (win_lo),
    .win_hi_o    (win_hi)
  );

  ob_xlat_lookup #(
    .NUM_WIN(NUM_WIN), .SIZE_W(SIZE_W),
    .REGION_BASE(REGION_BASE), .REGION_LIMIT(REGION_LIMIT)
  ) u_lookup (
    .addr_i   (in_addr_i),
    .en_i     (ctrl_q[EN_BIT]),
    .size_i   (size_q),
    .win_lo_i (win_lo),
    .win_hi_i (win_hi),
    .res_o    (look_res)
  );

  ob_xlat_stage u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_res_i    (look_res),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_res_o   (out_res)
  );

  assign out_addr_o = out_res.addr;
  assign out_hit_o  = out_res.hit;
endmodule

// File: rtl/ob_xlat_windows_chk.sv
module ob_xlat_windows_chk #(
  parameter logic [31:0] REGION_BASE  = 32'h4000_0000,
  parameter logic [31:0] REGION_LIMIT = 32'h4FFF_FFFF
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [31:0] in_addr_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [63:0] out_addr_o,
  input logic        out_hit_o,
  input logic        xlat_en
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o) && $stable(out_hit_o));

  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  assert_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  assert_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  assert_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !xlat_en |=> !out_hit_o);

  assert_outside_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && ((in_addr_i < REGION_BASE) || (in_addr_i > REGION_LIMIT))
    |=> !out_hit_o && (out_addr_o == {32'h0, $past(in_addr_i)}));

  assert_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_hit_o |-> out_addr_o[63:32] == 32'h0);
endmodule

bind ob_xlat_windows ob_xlat_windows_chk #(
  .REGION_BASE(REGION_BASE), .REGION_LIMIT(REGION_LIMIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_addr_i   (in_addr_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_addr_o  (out_addr_o),
  .out_hit_o   (out_hit_o),
  .xlat_en     (ctrl_q[1])
);

// File: tb/ob_xlat_windows_test.sv
`timescale 1ns/1ps
module ob_xlat_windows_test;
  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam logic [31:0] LIMIT = 32'h4FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = 12'h004;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_addr_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [63:0] out_addr_o;
  logic        out_hit_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  ob_xlat_windows uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_addr_i(in_addr_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_addr_o(out_addr_o), .out_hit_o(out_hit_o)
  );

  // reference state
  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];
  logic [31:0] m_ctrl;
  int          m_size;
  bit          q_hit [$];
  logic [63:0] q_addr [$];
  string       q_tag [$];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int off = int'(a);
    if (off == 'h004) return m_ctrl;
    if (off == 'h030) return 32'(m_size);
    if (off >= 'h200 && off < 'h300 && (off % 4) == 0) begin
      if (((off - 'h200) / 4) % 2 == 1) return m_hi[(off - 'h200) / 8];
      return m_lo[(off - 'h200) / 8];
    end
    return 32'h0;
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [31:0] d);
    int off = int'(a);
    if (off == 'h004) m_ctrl = d;
    else if (off == 'h030) m_size = int'(d % 8);
    else if (off >= 'h200 && off < 'h300 && (off % 4) == 0) begin
      if (((off - 'h200) / 4) % 2 == 1) m_hi[(off - 'h200) / 8] = d;
      else m_lo[(off - 'h200) / 8] = d;
    end
  endtask

  task automatic ref_xlat(input logic [31:0] a, output bit h, output logic [63:0] o);
    int sh = 20 + m_size;
    longint unsigned rel, wsize;
    int idx;
    h = 0;
    o = {32'h0, a};
    if (a >= BASE && a <= LIMIT) begin
      wsize = 64'd1 << sh;
      rel = longint'(a - BASE) / wsize;
      if (rel < 32) begin
        idx = int'(rel);
        if (m_lo[idx] % 2 == 1 && m_ctrl[1]) begin
          h = 1;
          o = {m_hi[idx], 32'h0} + 64'(m_lo[idx] - 32'd1) + (64'(a) % wsize);
        end
      end
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
      m_ctrl = '0; m_size = 0;
      q_hit.delete(); q_addr.delete(); q_tag.delete();
    end else begin : upd
      bit rdy, h;
      logic [63:0] o;
      rdy = (q_hit.size() == 0) || out_ready_i;
      if (q_hit.size() != 0 && out_ready_i) begin
        void'(q_hit.pop_front()); void'(q_addr.pop_front()); void'(q_tag.pop_front());
      end
      if (in_valid_i && rdy) begin
        ref_xlat(in_addr_i, h, o);
        q_hit.push_back(h); q_addr.push_back(o); q_tag.push_back(cur_tag);
      end
      if (reg_we_i) m_write(reg_addr_i, reg_wdata_i);
    end
  end

  always @(negedge clk) begin
    if (rst_ni === 1'b1 && !done) begin
      chk(out_valid_o === (q_hit.size() != 0), "R8 out_valid", 64'(out_valid_o), 64'(q_hit.size() != 0));
      chk(in_ready_o === ((q_hit.size() == 0) || out_ready_i), "R9 in_ready",
          64'(in_ready_o), 64'((q_hit.size() == 0) || out_ready_i));
      if (q_hit.size() != 0 && out_valid_o === 1'b1) begin
        chk(out_hit_o === q_hit[0], {q_tag[0], " hit"}, 64'(out_hit_o), 64'(q_hit[0]));
        chk(out_addr_o === q_addr[0], {q_tag[0], " addr"}, out_addr_o, q_addr[0]);
      end
      chk(reg_rdata_o === m_read(reg_addr_i), {cur_tag, " rdata"}, 64'(reg_rdata_o), 64'(m_read(reg_addr_i)));
    end
  end

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    reg_addr_i = a;
    cyc();
  endtask

  task automatic send(input logic [31:0] a);
    bit acc;
    in_valid_i = 1'b1; in_addr_i = a;
    do begin
      #1; acc = in_ready_o;
      cyc();
    end while (!acc);
  endtask

  task automatic idle();
    in_valid_i = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #3 rst_ni = 1'b1;
    cyc();
    cur_tag = "R1";
    rd(12'h004); rd(12'h030); rd(12'h200); rd(12'h2FC);
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R1 idle port", {out_valid_o, in_ready_o}, 64'b01);

    cur_tag = "R2";
    wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_0001);
    wr(12'h208, 32'h9000_0001); wr(12'h20C, 32'h0000_0002);
    wr(12'h210, 32'hC000_0001); wr(12'h214, 32'h0000_0004);
    wr(12'h228, 32'hB000_0000); wr(12'h22C, 32'h0000_0005);
    wr(12'h2F8, 32'hA000_0001); wr(12'h2FC, 32'hFFFF_FFFF);
    rd(12'h200); rd(12'h204); rd(12'h20C); rd(12'h228); rd(12'h2F8); rd(12'h2FC);

    cur_tag = "R3";
    wr(12'h030, 32'hFFFF_FFF9); rd(12'h030);
    wr(12'h030, 32'h0); rd(12'h030);

    cur_tag = "R7";
    send(BASE + 32'h123); idle();
    cur_tag = "R4";
    wr(12'h004, 32'hFFFF_FFFD); rd(12'h004);
    send(BASE + 32'h123); idle();
    wr(12'h004, 32'h0000_0005); rd(12'h004);
    wr(12'h004, 32'h0000_0007); rd(12'h004);

    cur_tag = "R6";
    send(BASE + 32'h123); send(BASE + 32'hF_FFFF); idle();
    cur_tag = "R5";
    send(BASE + 32'h10_0045); send(BASE + 32'h1F0_0010); send(BASE + 32'h20_0000); idle();
    cur_tag = "R7";
    send(BASE + 32'h50_0000); send(BASE + 32'h200_0000); send(BASE - 32'd1);
    send(LIMIT + 32'd1); send(32'h0000_1000); idle();

    cur_tag = "R5";
    wr(12'h030, 32'h2);
    send(BASE + 32'h70_0000); send(BASE + 32'h3F_FFFF); send(BASE + 32'hB0_0004); idle();
    wr(12'h030, 32'h7);
    send(BASE + 32'h0A00_0000); send(BASE + 32'h07FF_FFFF); send(LIMIT); idle();

    cur_tag = "R9";
    wr(12'h030, 32'h0);
    out_ready_i = 1'b0;
    send(BASE + 32'h11);
    in_addr_i = BASE + 32'h10_0022;
    cyc(); cyc(); cyc();
    out_ready_i = 1'b1;
    cyc(); cyc();
    idle();

    cur_tag = "R11";
    in_valid_i = 1'b1; in_addr_i = BASE + 32'h33;
    reg_we_i = 1'b1; reg_addr_i = 12'h200; reg_wdata_i = 32'hD000_0001;
    cyc();
    reg_we_i = 1'b0;
    idle();
    send(BASE + 32'h33); idle();

    cur_tag = "R10";
    wr(12'h100, 32'hDEAD_BEEF); rd(12'h100);
    wr(12'h300, 32'h1234_5679); rd(12'h300);
    wr(12'h202, 32'h5555_5555); rd(12'h200); rd(12'h202);
    rd(12'h010);
    send(BASE + 32'h44); idle();

    cur_tag = "R8";
    out_ready_i = 1'b1;
    for (int i = 0; i < 8; i++) send(BASE + 32'(i) * 32'h10_0000 + 32'(i));
    idle(); idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule